// File: doc/BRIEF.md
# G.711 Companding Converter Pair

This block carries two independent, registered converters between 8-bit companded audio codes and a 16-bit two's-complement linear word. The expand path turns a companded code into a linear sample for a playback converter. The compress path turns a linear sample from a capture converter into a companded code. A single law-select input chooses µ-law or A-law, and that choice applies to both paths in the same cycle. Both laws follow the G.711 segment structure, which spends its precision at small amplitudes. At large amplitudes the resolution is roughly six bits.

The linear word is aligned to the top of the 16-bit field. A µ-law value uses the upper 13 bits and an A-law value uses the upper 12 bits. The unused low bits are zero on expansion and are discarded (floor truncation) on compression. Each path has its own valid strobe. A result appears one clock after its input, and the output data is held while that path's valid is low.

Sign convention for codes: for µ-law, invert the code, and then bit 7 = 1 means positive, bits 6:4 are the segment and bits 3:0 are the step. For A-law, XOR the code with 55h, and then bit 7 = 0 means positive, with the same segment and step fields. This places full scale at 00h/80h (µ-law) and 2Ah/AAh (A-law), with zero at 7Fh/FFh and 55h/D5h.

Top module: `g711_codec`

## Requirements
- R1: Each path registers its result. `exp_vld_o`/`cmp_vld_o` equal the matching input valid of the previous cycle, and a synchronous active-high `rst` drives every output to zero.
- R2: In µ-law mode (`law_alaw_i`=0), code with segment e and step m (fields after inversion) expands to magnitude (((8m+132)<<e)−132) with bits 2:0 cleared. The result is negated when the inverted bit 7 is 0. Code 00h gives +32120 (7D78h) and 80h gives −32120.
- R3: In A-law mode (`law_alaw_i`=1), after XOR with 55h the magnitude is 16m+8 for e=0 and (16m+264)<<(e−1) otherwise, with bits 3:0 cleared. The result is negated when bit 7 is 1. Code 2Ah gives +32256 (7E00h) and AAh gives −32256.
- R4: An expanded word has bits 2:0 zero in µ-law mode and bits 3:0 zero in A-law mode.
- R5: Both zero codes of each law (7Fh and FFh for µ-law, 55h and D5h for A-law) expand to 0000h.
- R6: In µ-law mode, compression picks the largest code whose lower decision edge ((8m+128)<<e)−132 does not exceed the input magnitude. Expanding any µ-law code and compressing the result returns the same code, except that FFh returns as 7Fh.
- R7: In A-law mode, compression picks the largest code whose lower edge (16m for e=0, (16m+256)<<(e−1) otherwise) does not exceed the input magnitude. The round trip from expansion returns every code, except that D5h returns as 55h.
- R8: Compression ignores the low 3 input bits (µ-law) or low 4 bits (A-law). The input is floored to that grid before its magnitude is taken.
- R9: Inputs beyond the top segment saturate. 8000h compresses to 80h (µ-law) or AAh (A-law), and 7FFFh compresses to 00h (µ-law) or 2Ah (A-law).
- R10: An input of exactly 0000h compresses to 7Fh in µ-law mode and 55h in A-law mode.
- R11: The two paths work in the same cycle without interaction. While a path's valid input is low, its output data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| law_alaw_i | input | 1 | Law select: 0 = µ-law, 1 = A-law (both paths) |
| exp_vld_i | input | 1 | Expand input valid |
| exp_code_i | input | 8 | Companded code to expand |
| cmp_vld_i | input | 1 | Compress input valid |
| cmp_lin_i | input | 16 | Linear two's-complement sample to compress |
| exp_vld_o | output | 1 | Expand result valid |
| exp_lin_o | output | 16 | Expanded linear sample |
| cmp_vld_o | output | 1 | Compress result valid |
| cmp_code_o | output | 8 | Compressed code |

## Verification
An expansion and a compression can complete in the same clock edge, and the law select governs both of them. The bench therefore drives both paths together in every cycle. During the exhaustive sweep, the compress input carries the bench-computed expansion of the code being expanded. Each cycle is judged twice: the expand output is compared against the bench table, and the compress output must return the original code or its zero alias. Random cycles vary both valids and the law, so that a hold on one path coincides with new data on the other.

// File: rtl/g711_pkg.sv
package g711_pkg;

    localparam int LIN_W    = 16;
    localparam int MAG_W    = LIN_W + 1;
    localparam int CODE_W   = 8;
    localparam int SEG_W    = 3;
    localparam int STEP_W   = 4;
    localparam int NUM_LAWS = 2;
    localparam int MU_DROP  = 3;
    localparam int A_DROP   = 4;
    localparam int MU_BIAS  = 132;
    localparam int A_SEG1   = 264;
    localparam logic [CODE_W-1:0] A_TOGGLE = 8'h55;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    typedef struct packed {
        logic              neg;
        logic [SEG_W-1:0]  seg;
        logic [STEP_W-1:0] step;
    } cfield_t;

    function automatic logic [SEG_W-1:0] top_bit(input logic [7:0] w);
        logic [SEG_W-1:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (w[i]) r = SEG_W'(i);
        end
        return r;
    endfunction

    function automatic cfield_t unpack_code(input law_e law, input logic [CODE_W-1:0] code);
        cfield_t f;
        logic [CODE_W-1:0] t;
        if (law == LAW_MU) begin
            t = ~code;
            f.neg = ~t[7];
        end else begin
            t = code ^ A_TOGGLE;
            f.neg = t[7];
        end
        f.seg  = t[6:4];
        f.step = t[3:0];
        return f;
    endfunction

    function automatic logic [CODE_W-1:0] pack_code(input law_e law, input cfield_t f);
        logic [CODE_W-1:0] r;
        if (law == LAW_MU) r = ~{~f.neg, f.seg, f.step};
        else               r = {f.neg, f.seg, f.step} ^ A_TOGGLE;
        return r;
    endfunction

    function automatic logic [MAG_W-1:0] grid_mask(input law_e law);
        int drop;
        drop = (law == LAW_MU) ? MU_DROP : A_DROP;
        return ~MAG_W'((1 << drop) - 1);
    endfunction

endpackage

// File: rtl/g711_expand_core.sv
module g711_expand_core
    import g711_pkg::*;
#(
    parameter law_e LAW = LAW_MU
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LIN_W-1:0]  lin_o
);
    localparam logic [MAG_W-1:0] KEEP = grid_mask(LAW);

    cfield_t          fld;
    logic [MAG_W-1:0] raw_mag;
    logic [MAG_W-1:0] grid_mag;
    logic [MAG_W-1:0] neg_mag;

    assign fld = unpack_code(LAW, code_i);

    generate
        if (LAW == LAW_MU) begin : g_mu
            logic [MAG_W-1:0] base;
            always_comb begin
                base    = (MAG_W'(fld.step) << 3) + MAG_W'(MU_BIAS);
                raw_mag = (base << fld.seg) - MAG_W'(MU_BIAS);
            end
        end else begin : g_a
            logic [MAG_W-1:0] base;
            always_comb begin
                base = (MAG_W'(fld.step) << 4) + MAG_W'(A_SEG1);
                if (fld.seg == '0) raw_mag = (MAG_W'(fld.step) << 4) + MAG_W'(8);
                else               raw_mag = base << (fld.seg - SEG_W'(1));
            end
        end
    endgenerate

    always_comb begin
        grid_mag = raw_mag & KEEP;
        neg_mag  = MAG_W'(0) - grid_mag;
        lin_o    = fld.neg ? neg_mag[LIN_W-1:0] : grid_mag[LIN_W-1:0];
    end

endmodule

// File: rtl/g711_compress_core.sv
module g711_compress_core
    import g711_pkg::*;
#(
    parameter law_e LAW = LAW_MU
) (
    input  logic [LIN_W-1:0]  lin_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [MAG_W-1:0] KEEP = grid_mask(LAW);

    logic             is_neg;
    logic [MAG_W-1:0] floored;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] probe;
    logic [MAG_W-1:0] shifted;
    logic [7:0]       window;
    logic [SEG_W-1:0] seg;
    logic [3:0]       shamt;
    logic             sat;
    cfield_t          fld;

    always_comb begin
        is_neg  = lin_i[LIN_W-1];
        floored = {lin_i[LIN_W-1], lin_i} & KEEP;
        mag     = is_neg ? (MAG_W'(0) - floored) : floored;
    end

    generate
        if (LAW == LAW_MU) begin : g_mu
            always_comb begin
                probe  = mag + MAG_W'(MU_BIAS);
                sat    = probe[MAG_W-1] | probe[MAG_W-2];
                window = probe[14:7];
                seg    = top_bit(window);
                shamt  = {1'b0, seg} + 4'd3;
            end
        end else begin : g_a
            always_comb begin
                probe  = mag;
                sat    = probe[MAG_W-1] | probe[MAG_W-2];
                window = {probe[14:8], 1'b1};
                seg    = top_bit(window);
                shamt  = (seg == '0) ? 4'd4 : ({1'b0, seg} + 4'd3);
            end
        end
    endgenerate

    always_comb begin
        shifted = probe >> shamt;
        fld.neg = is_neg;
        if (sat) begin
            fld.seg  = '1;
            fld.step = '1;
        end else begin
            fld.seg  = seg;
            fld.step = shifted[STEP_W-1:0];
        end
        code_o = pack_code(LAW, fld);
    end

endmodule

// File: rtl/g711_codec.sv
module g711_codec
    import g711_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        law_alaw_i,
    input  logic        exp_vld_i,
    input  logic [7:0]  exp_code_i,
    input  logic        cmp_vld_i,
    input  logic [15:0] cmp_lin_i,
    output logic        exp_vld_o,
    output logic [15:0] exp_lin_o,
    output logic        cmp_vld_o,
    output logic [7:0]  cmp_code_o
);
    logic [LIN_W-1:0]  lin_by_law  [NUM_LAWS];
    logic [CODE_W-1:0] code_by_law [NUM_LAWS];
    logic [LIN_W-1:0]  lin_sel;
    logic [CODE_W-1:0] code_sel;

    generate
        for (genvar g = 0; g < NUM_LAWS; g++) begin : g_law
            g711_expand_core #(.LAW(law_e'(g))) u_exp (
                .code_i (exp_code_i),
                .lin_o  (lin_by_law[g])
            );
            g711_compress_core #(.LAW(law_e'(g))) u_cmp (
                .lin_i  (cmp_lin_i),
                .code_o (code_by_law[g])
            );
        end
    endgenerate

    always_comb begin
        lin_sel  = lin_by_law[law_alaw_i];
        code_sel = code_by_law[law_alaw_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_vld_o  <= 1'b0;
            exp_lin_o  <= '0;
            cmp_vld_o  <= 1'b0;
            cmp_code_o <= '0;
        end else begin
            exp_vld_o <= exp_vld_i;
            cmp_vld_o <= cmp_vld_i;
            if (exp_vld_i) exp_lin_o  <= lin_sel;
            if (cmp_vld_i) cmp_code_o <= code_sel;
        end
    end

endmodule

// File: rtl/g711_codec_chk.sv
module g711_codec_chk (
    input logic        clk,
    input logic        rst,
    input logic        law_alaw_i,
    input logic        exp_vld_i,
    input logic [7:0]  exp_code_i,
    input logic        cmp_vld_i,
    input logic [15:0] cmp_lin_i,
    input logic        exp_vld_o,
    input logic [15:0] exp_lin_o,
    input logic        cmp_vld_o,
    input logic [7:0]  cmp_code_o
);
    assert_exp_vld_rise_R1: assert property (@(posedge clk) disable iff (rst)
        exp_vld_i |=> exp_vld_o);
    assert_cmp_vld_drop_R1: assert property (@(posedge clk) disable iff (rst)
        !cmp_vld_i |=> !cmp_vld_o);
    assert_mu_pos_sign_R2: assert property (@(posedge clk) disable iff (rst)
        exp_vld_i && !law_alaw_i && !exp_code_i[7] |=> !exp_lin_o[15]);
    assert_a_pos_sign_R3: assert property (@(posedge clk) disable iff (rst)
        exp_vld_i && law_alaw_i && !exp_code_i[7] |=> !exp_lin_o[15]);
    assert_mu_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
        exp_vld_i && !law_alaw_i |=> exp_lin_o[2:0] == 3'b000);
    assert_a_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
        exp_vld_i && law_alaw_i |=> exp_lin_o[3:0] == 4'b0000);
    assert_zero_alias_R5: assert property (@(posedge clk) disable iff (rst)
        exp_vld_i && ((!law_alaw_i && (exp_code_i == 8'h7F || exp_code_i == 8'hFF)) ||
                      ( law_alaw_i && (exp_code_i == 8'h55 || exp_code_i == 8'hD5)))
        |=> exp_lin_o == 16'h0000);
    assert_neg_sat_R9: assert property (@(posedge clk) disable iff (rst)
        cmp_vld_i && cmp_lin_i == 16'h8000
        |=> cmp_code_o == ($past(law_alaw_i) ? 8'hAA : 8'h80));
    assert_zero_code_R10: assert property (@(posedge clk) disable iff (rst)
        cmp_vld_i && cmp_lin_i == 16'h0000
        |=> cmp_code_o == ($past(law_alaw_i) ? 8'h55 : 8'h7F));
    assert_exp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !exp_vld_i |=> $stable(exp_lin_o));
    assert_cmp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !cmp_vld_i |=> $stable(cmp_code_o));
endmodule

bind g711_codec g711_codec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .law_alaw_i (law_alaw_i),
    .exp_vld_i  (exp_vld_i),
    .exp_code_i (exp_code_i),
    .cmp_vld_i  (cmp_vld_i),
    .cmp_lin_i  (cmp_lin_i),
    .exp_vld_o  (exp_vld_o),
    .exp_lin_o  (exp_lin_o),
    .cmp_vld_o  (cmp_vld_o),
    .cmp_code_o (cmp_code_o)
);

// File: tb/tb_g711_codec.sv
`timescale 1ns/1ps
module tb_g711_codec;
    logic        clk = 1'b0;
    logic        rst;
    logic        law_alaw_i;
    logic        exp_vld_i;
    logic [7:0]  exp_code_i;
    logic        cmp_vld_i;
    logic [15:0] cmp_lin_i;
    logic        exp_vld_o;
    logic [15:0] exp_lin_o;
    logic        cmp_vld_o;
    logic [7:0]  cmp_code_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    g711_codec dut (
        .clk(clk), .rst(rst), .law_alaw_i(law_alaw_i),
        .exp_vld_i(exp_vld_i), .exp_code_i(exp_code_i),
        .cmp_vld_i(cmp_vld_i), .cmp_lin_i(cmp_lin_i),
        .exp_vld_o(exp_vld_o), .exp_lin_o(exp_lin_o),
        .cmp_vld_o(cmp_vld_o), .cmp_code_o(cmp_code_o)
    );

    function automatic logic [15:0] ref_expand(input bit law, input logic [7:0] code);
        logic [7:0] t;
        int e, m, v;
        bit neg;
        if (!law) begin
            t = ~code; neg = ~t[7];
        end else begin
            t = code ^ 8'h55; neg = t[7];
        end
        e = int'(t[6:4]); m = int'(t[3:0]);
        if (!law) v = (4 * (((2 * m + 33) << e) - 33)) & ~7;
        else if (e == 0) v = (8 * (2 * m + 1)) & ~15;
        else v = (8 * ((2 * m + 33) << (e - 1))) & ~15;
        if (neg) v = -v;
        return v[15:0];
    endfunction

    function automatic logic [7:0] ref_compress(input bit law, input logic [15:0] x);
        int xs, mag, best, e, m, edge_v;
        bit neg;
        xs  = int'($signed(x));
        xs  = law ? (xs & ~15) : (xs & ~7);
        neg = xs < 0;
        mag = neg ? -xs : xs;
        best = 0;
        for (int idx = 0; idx < 128; idx++) begin
            e = idx >> 4; m = idx & 15;
            if (!law) edge_v = 4 * (((2 * m + 32) << e) - 33);
            else if (e == 0) edge_v = 16 * m;
            else edge_v = 8 * ((2 * m + 32) << (e - 1));
            if (edge_v <= mag) best = idx;
        end
        if (!law) return neg ? ~8'(best) : ~(8'h80 | 8'(best));
        else      return neg ? ((8'h80 | 8'(best)) ^ 8'h55) : (8'(best) ^ 8'h55);
    endfunction

    task automatic chk(input string req, input int got, input int expv);
        total++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, got, expv);
        end
    endtask

    task automatic drive(input bit law, input bit ev, input logic [7:0] ec,
                         input bit cv, input logic [15:0] cl);
        law_alaw_i = law; exp_vld_i = ev; exp_code_i = ec;
        cmp_vld_i = cv; cmp_lin_i = cl;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  zc, held_code, c1;
        logic [15:0] held_lin, xr;
        bit lw;
        void'($urandom(32'd7211));
        rst = 1'b1;
        law_alaw_i = 1'b0; exp_vld_i = 1'b0; exp_code_i = '0;
        cmp_vld_i = 1'b0; cmp_lin_i = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset exp_vld", int'(exp_vld_o), 0);
        chk("R1 reset exp_lin", int'(exp_lin_o), 0);
        chk("R1 reset cmp_vld", int'(cmp_vld_o), 0);
        chk("R1 reset cmp_code", int'(cmp_code_o), 0);
        rst = 1'b0;

        // exhaustive expand, concurrent round trip through compress (R2 R3 R4 R5 R6 R7 R11)
        for (int l = 0; l < 2; l++) begin
            for (int c = 0; c < 256; c++) begin
                drive(bit'(l), 1'b1, 8'(c), 1'b1, ref_expand(bit'(l), 8'(c)));
                chk("R1 exp_vld", int'(exp_vld_o), 1);
                chk(l ? "R3 expand" : "R2 expand", int'(exp_lin_o), int'(ref_expand(bit'(l), 8'(c))));
                chk("R4 low bits", int'(l ? exp_lin_o[3:0] : {1'b0, exp_lin_o[2:0]}), 0);
                zc = 8'(c);
                if (!l && zc == 8'hFF) zc = 8'h7F;
                if (l && zc == 8'hD5) zc = 8'h55;
                chk(l ? "R7 round trip" : "R6 round trip", int'(cmp_code_o), int'(zc));
            end
        end

        // R5 zero aliases, directed
        drive(1'b0, 1'b1, 8'hFF, 1'b0, 16'h0);
        chk("R5 mu FF", int'(exp_lin_o), 0);
        drive(1'b1, 1'b1, 8'hD5, 1'b0, 16'h0);
        chk("R5 A D5", int'(exp_lin_o), 0);
        drive(1'b0, 1'b1, 8'h00, 1'b0, 16'h0);
        chk("R2 mu +FS", int'(exp_lin_o), 32'h7D78);
        drive(1'b1, 1'b1, 8'hAA, 1'b0, 16'h0);
        chk("R3 A -FS", int'(exp_lin_o), 32'h8200);

        // R9 saturation, R10 zero
        for (int l = 0; l < 2; l++) begin
            drive(bit'(l), 1'b0, 8'h0, 1'b1, 16'h8000);
            chk("R9 neg sat", int'(cmp_code_o), l ? 32'hAA : 32'h80);
            drive(bit'(l), 1'b0, 8'h0, 1'b1, 16'h7FFF);
            chk("R9 pos sat", int'(cmp_code_o), l ? 32'h2A : 32'h00);
            drive(bit'(l), 1'b0, 8'h0, 1'b1, 16'h0000);
            chk("R10 zero code", int'(cmp_code_o), l ? 32'h55 : 32'h7F);
        end

        // R8 low bits ignored
        for (int i = 0; i < 200; i++) begin
            lw = bit'($urandom_range(1, 0));
            xr = 16'($urandom);
            drive(lw, 1'b0, 8'h0, 1'b1, lw ? (xr & 16'hFFF0) : (xr & 16'hFFF8));
            c1 = cmp_code_o;
            drive(lw, 1'b0, 8'h0, 1'b1, lw ? (xr | 16'h000F) : (xr | 16'h0007));
            chk("R8 low bits ignored", int'(cmp_code_o), int'(c1));
        end

        // random mixed traffic: compress R6/R7, hold R11, valid R1
        held_lin = exp_lin_o; held_code = cmp_code_o;
        for (int i = 0; i < 3000; i++) begin
            bit ev, cv;
            logic [7:0] ec;
            lw = bit'($urandom_range(1, 0));
            ev = bit'($urandom_range(1, 0));
            cv = bit'($urandom_range(1, 0));
            ec = 8'($urandom);
            xr = 16'($urandom);
            drive(lw, ev, ec, cv, xr);
            chk("R1 exp_vld follow", int'(exp_vld_o), int'(ev));
            chk("R1 cmp_vld follow", int'(cmp_vld_o), int'(cv));
            if (ev) held_lin = ref_expand(lw, ec);
            if (cv) held_code = ref_compress(lw, xr);
            chk(ev ? (lw ? "R3 random expand" : "R2 random expand") : "R11 exp hold",
                int'(exp_lin_o), int'(held_lin));
            chk(cv ? (lw ? "R7 random compress" : "R6 random compress") : "R11 cmp hold",
                int'(cmp_code_o), int'(held_code));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule